// File: doc/BRIEF.md
# Receive Packet Buffer Fill Controller

This block takes a stream of received bytes, each tagged with start-of-packet and end-of-packet markers, and places them one after another into a chain of equally sized memory buffers. Every accepted byte turns into a single write strobe carrying the byte and its offset inside the current buffer. The block decides when a buffer is finished and raises a one-cycle done pulse on the same cycle as that buffer's last write. A packet that does not fit in the space left carries on into the next buffer, at offset zero.

Two fill modes exist. In single-packet mode each buffer holds no more than one packet, so a buffer closes when its packet ends or when it is full. In multiple-packet mode packets are packed back to back, and a buffer closes when it is full. It also closes when a packet ends with exactly one byte of the buffer still unused, because that byte is too small to be useful. When a buffer closes, the block reports whether its first byte opened a packet. Address generation and bus signalling belong to the surrounding logic. The consumer signals through a level input that a fresh buffer is ready, and the block stalls the stream until one is.

Top module: `rx_fill_ctrl`

## Requirements
- R1: In single-packet mode (`multi_mode` = 0), a write whose byte carries end-of-packet is flagged with `buf_done` = 1.
- R2: In single-packet mode, the write at offset depth-1 is flagged with `buf_done` = 1 even when the byte carries no end-of-packet, and the packet's remaining bytes follow in the next buffer.
- R3: In multiple-packet mode (`multi_mode` = 1), the write at offset depth-1 is flagged with `buf_done` = 1.
- R4: In multiple-packet mode, a byte carrying end-of-packet at offset depth-2 closes the buffer (`buf_done` = 1 on that write).
- R5: In multiple-packet mode, a byte carrying end-of-packet at an offset below depth-2 does not close the buffer, and the next packet's bytes continue at the following offsets of the same buffer.
- R6: After a buffer closes, the next accepted byte is written at offset 0 of a new buffer.
- R7: Within a buffer, accepted bytes are written at consecutive offsets starting from 0, and `wr_data` equals the accepted byte.
- R8: A byte accepted at a rising edge (`in_valid` and `in_ready` both 1) appears as `wr_en` = 1 for exactly one cycle after that edge. `buf_done` is only ever 1 together with `wr_en`.
- R9: `buf_pkt_start` is 1 only with `buf_done`. In single-packet mode it equals the start-of-packet marker of the closed buffer's first byte. In multiple-packet mode it is always 0.
- R10: When no buffer is open and `buf_avail` = 0, `in_ready` is 0 and no write happens. Once a buffer is open, `in_ready` is 1 whatever `buf_avail` is. A byte held during a stall is written unchanged once accepted.
- R11: After reset `wr_en`, `buf_done` and `buf_pkt_start` are 0, no buffer is open, and the first accepted byte is written at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Received byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| multi_mode | input | 1 | 0 = one packet per buffer, 1 = packed packets; sampled at a buffer's first byte |
| buf_depth | input | DEPTH_W | Buffer size in bytes (at least 2); sampled at a buffer's first byte |
| buf_avail | input | 1 | A fresh buffer is ready to be opened |
| wr_en | output | 1 | Write strobe |
| wr_offset | output | DEPTH_W | Byte offset of the write inside the current buffer |
| wr_data | output | 8 | Byte to write |
| buf_done | output | 1 | Current buffer closes with this write |
| buf_pkt_start | output | 1 | With `buf_done`: the closed buffer began with a packet start |

## Verification
The bench builds the block with `DEPTH_W` = 4, so buffers of 2 to 15 bytes are possible and most vectors use a 4-byte buffer. With buffers that small, a packet crosses a buffer edge within a few bytes. Both close rules and the early close at depth-2 come up often, as do continuations across two buffers and a buffer that a single-byte packet closes at offset 0 in a 2-byte buffer. The stall path and a reset in the middle of a buffer are tested as directed cases after the vector walk.

// File: rtl/rx_fill_pkg.sv
package rx_fill_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        FILL_SINGLE = 1'b0,
        FILL_MULTI  = 1'b1
    } fill_mode_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BYTE_W-1:0] data;
    } beat_t;

    // Close decision from the position flags of the current byte.
    function automatic logic close_now(fill_mode_e mode, logic eop,
                                       logic at_last, logic at_penult);
        logic by_eop;
        by_eop = (mode == FILL_SINGLE) ? eop : (eop && at_penult);
        return at_last || by_eop;
    endfunction

endpackage

// File: rtl/rx_fill_close.sv
module rx_fill_close
    import rx_fill_pkg::*;
#(
    parameter int DEPTH_W = 13
) (
    input  fill_mode_e         mode,
    input  logic               eop,
    input  logic [DEPTH_W-1:0] off,
    input  logic [DEPTH_W-1:0] depth,
    output logic               done
);
    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);
    localparam logic [DEPTH_W-1:0] TWO = DEPTH_W'(2);

    logic at_last;
    logic at_penult;

    always_comb begin
        at_last   = (off == (depth - ONE));
        at_penult = (off == (depth - TWO));
        done      = close_now(mode, eop, at_last, at_penult);
    end

endmodule

// File: rtl/rx_fill_track.sv
module rx_fill_track
    import rx_fill_pkg::*;
#(
    parameter int DEPTH_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               sop,
    input  logic               done,
    input  fill_mode_e         mode_in,
    input  logic [DEPTH_W-1:0] depth_in,
    output logic               open_o,
    output logic [DEPTH_W-1:0] cur_off,
    output fill_mode_e         eff_mode,
    output logic [DEPTH_W-1:0] eff_depth,
    output logic               eff_ps
);
    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

    logic               open_q;
    logic [DEPTH_W-1:0] off_q;
    logic [DEPTH_W-1:0] depth_q;
    fill_mode_e         mode_q;
    logic               ps_q;

    // Mode, depth and packet-start freeze at the first byte of a buffer.
    always_comb begin
        open_o    = open_q;
        cur_off   = open_q ? off_q   : '0;
        eff_mode  = open_q ? mode_q  : mode_in;
        eff_depth = open_q ? depth_q : depth_in;
        eff_ps    = open_q ? ps_q    : sop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            off_q   <= '0;
            depth_q <= '0;
            mode_q  <= FILL_SINGLE;
            ps_q    <= 1'b0;
        end else if (accept) begin
            if (!open_q) begin
                mode_q  <= mode_in;
                depth_q <= depth_in;
                ps_q    <= sop;
            end
            if (done) begin
                open_q <= 1'b0;
                off_q  <= '0;
            end else begin
                open_q <= 1'b1;
                off_q  <= cur_off + ONE;
            end
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && !accept) |=> (open_q && $stable(off_q)));

endmodule

// File: rtl/rx_fill_wr.sv
module rx_fill_wr
    import rx_fill_pkg::*;
#(
    parameter int DEPTH_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  beat_t              beat,
    input  logic               done,
    input  fill_mode_e         eff_mode,
    input  logic               eff_ps,
    input  logic [DEPTH_W-1:0] cur_off,
    input  logic [DEPTH_W-1:0] eff_depth,
    output logic               wr_en,
    output logic [DEPTH_W-1:0] wr_offset,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               buf_done,
    output logic               buf_pkt_start
);
    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);
    localparam logic [DEPTH_W-1:0] TWO = DEPTH_W'(2);

    typedef struct packed {
        logic               en;
        logic [DEPTH_W-1:0] off;
        logic [BYTE_W-1:0]  data;
        logic               done;
        logic               ps;
        logic               eop;
        fill_mode_e         mode;
        logic [DEPTH_W-1:0] depth;
    } wr_rec_t;

    wr_rec_t rec_q;
    wr_rec_t rec_d;

    always_comb begin
        rec_d.en    = accept;
        rec_d.off   = cur_off;
        rec_d.data  = beat.data;
        rec_d.done  = accept && done;
        rec_d.ps    = accept && done && eff_ps && (eff_mode == FILL_SINGLE);
        rec_d.eop   = beat.eop;
        rec_d.mode  = eff_mode;
        rec_d.depth = eff_depth;
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

    assign wr_en         = rec_q.en;
    assign wr_offset     = rec_q.off;
    assign wr_data       = rec_q.data;
    assign buf_done      = rec_q.done;
    assign buf_pkt_start = rec_q.ps;

    // History of the write stream, used only by the checks below.
    logic               after_close_q;
    logic [DEPTH_W-1:0] prev_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            after_close_q <= 1'b1;
            prev_off_q    <= '0;
        end else if (rec_q.en) begin
            after_close_q <= rec_q.done;
            prev_off_q    <= rec_q.off;
        end
    end

    // R8
    done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        buf_done |-> wr_en);

    // R7
    offset_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !after_close_q) |-> (wr_offset == prev_off_q + ONE));

    // R6
    offset_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && after_close_q) |-> (wr_offset == '0));

    // R3
    offset_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_offset == rec_q.depth - ONE) |-> buf_done);

    // R4
    early_close_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rec_q.mode == FILL_MULTI && rec_q.eop
         && wr_offset == rec_q.depth - TWO) |-> buf_done);

    // R5
    keep_open_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rec_q.mode == FILL_MULTI && rec_q.eop
         && (wr_offset + TWO) < rec_q.depth) |-> !buf_done);

    // R9
    multi_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_q.mode == FILL_MULTI || !buf_done) |-> !buf_pkt_start);

endmodule

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl
    import rx_fill_pkg::*;
#(
    parameter int DEPTH_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic               multi_mode,
    input  logic [DEPTH_W-1:0] buf_depth,
    input  logic               buf_avail,
    output logic               wr_en,
    output logic [DEPTH_W-1:0] wr_offset,
    output logic [7:0]         wr_data,
    output logic               buf_done,
    output logic               buf_pkt_start
);
    beat_t              beat;
    logic               accept;
    logic               open;
    logic               done;
    logic               eff_ps;
    fill_mode_e         eff_mode;
    logic [DEPTH_W-1:0] cur_off;
    logic [DEPTH_W-1:0] eff_depth;

    assign beat     = '{sop: in_sop, eop: in_eop, data: in_data};
    assign in_ready = open || buf_avail;
    assign accept   = in_valid && in_ready;

    rx_fill_track #(.DEPTH_W(DEPTH_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .sop       (beat.sop),
        .done      (done),
        .mode_in   (fill_mode_e'(multi_mode)),
        .depth_in  (buf_depth),
        .open_o    (open),
        .cur_off   (cur_off),
        .eff_mode  (eff_mode),
        .eff_depth (eff_depth),
        .eff_ps    (eff_ps)
    );

    rx_fill_close #(.DEPTH_W(DEPTH_W)) u_close (
        .mode  (eff_mode),
        .eop   (beat.eop),
        .off   (cur_off),
        .depth (eff_depth),
        .done  (done)
    );

    rx_fill_wr #(.DEPTH_W(DEPTH_W)) u_wr (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .beat          (beat),
        .done          (done),
        .eff_mode      (eff_mode),
        .eff_ps        (eff_ps),
        .cur_off       (cur_off),
        .eff_depth     (eff_depth),
        .wr_en         (wr_en),
        .wr_offset     (wr_offset),
        .wr_data       (wr_data),
        .buf_done      (buf_done),
        .buf_pkt_start (buf_pkt_start)
    );

    // R10
    no_write_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |=> !wr_en);

    // R8
    single_cycle_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept) |=> !wr_en);

endmodule

// File: tb/sim_rx_fill_ctrl.sv
`timescale 1ns/1ps
module sim_rx_fill_ctrl;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [7:0]    in_data;
    logic          in_sop;
    logic          in_eop;
    logic          multi_mode;
    logic [DW-1:0] buf_depth;
    logic          buf_avail;
    logic          wr_en;
    logic [DW-1:0] wr_offset;
    logic [7:0]    wr_data;
    logic          buf_done;
    logic          buf_pkt_start;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_fill_ctrl #(.DEPTH_W(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .multi_mode(multi_mode), .buf_depth(buf_depth), .buf_avail(buf_avail),
        .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
        .buf_done(buf_done), .buf_pkt_start(buf_pkt_start)
    );

    // Vector: {sop, eop, multi, exp_done, exp_ps, exp_off[3:0]}, depth 4 bytes.
    localparam int NV = 27;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_0_0_0_0000, 9'b0_1_0_1_1_0001,
        9'b1_0_0_0_0_0000, 9'b0_0_0_0_0_0001, 9'b0_0_0_0_0_0010,
        9'b0_0_0_1_1_0011, 9'b0_0_0_0_0_0000, 9'b0_1_0_1_0_0001,
        9'b1_0_0_0_0_0000, 9'b0_0_0_0_0_0001, 9'b0_0_0_0_0_0010,
        9'b0_1_0_1_1_0011,
        9'b1_0_1_0_0_0000, 9'b0_1_1_0_0_0001, 9'b1_1_1_1_0_0010,
        9'b1_0_1_0_0_0000, 9'b0_0_1_0_0_0001, 9'b0_0_1_0_0_0010,
        9'b0_0_1_1_0_0011, 9'b0_0_1_0_0_0000, 9'b0_1_1_0_0_0001,
        9'b1_0_1_0_0_0010, 9'b0_0_1_1_0_0011, 9'b0_1_1_0_0_0000,
        9'b1_1_1_0_0_0001, 9'b1_0_1_0_0_0010, 9'b0_1_1_1_0_0011
    };

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e,
                         input logic [7:0] d);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
    endtask

    function automatic string vec_tag(input logic [8:0] v);
        if (!v[6] && v[5] && v[7])  return "R1";
        if (!v[6] && v[5])          return "R2";
        if (v[6] && v[5] && v[7])   return "R4";
        if (v[6] && v[5])           return "R3";
        if (v[6] && v[7])           return "R5";
        return "R7";
    endfunction

    task automatic check_write(input string tag, input logic [DW-1:0] off,
                               input logic [7:0] d, input logic dn, input logic ps);
        chk("R8", {tag, " wr_en"}, 16'(wr_en), 16'd1);
        chk(tag, "wr_offset", 16'(wr_offset), 16'(off));
        chk("R7", "wr_data", 16'(wr_data), 16'(d));
        chk(tag, "buf_done", 16'(buf_done), 16'(dn));
        chk("R9", "buf_pkt_start", 16'(buf_pkt_start), 16'(ps));
    endtask

    initial begin
        rst = 1'b1; buf_avail = 1'b0; multi_mode = 1'b0; buf_depth = DW'(4);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        // R11 reset state, R10 no buffer and none available
        chk("R11", "wr_en after reset", 16'(wr_en), 16'd0);
        chk("R11", "buf_done after reset", 16'(buf_done), 16'd0);
        chk("R11", "buf_pkt_start after reset", 16'(buf_pkt_start), 16'd0);
        chk("R10", "in_ready without buffer", 16'(in_ready), 16'd0);
        rst = 1'b0; buf_avail = 1'b1;
        #0.5;
        chk("R10", "in_ready with buffer available", 16'(in_ready), 16'd1);

        // Vector walk, one byte per cycle, byte value = vector index.
        multi_mode = VEC[0][6];
        drive(1'b1, VEC[0][8], VEC[0][7], 8'd0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check_write(vec_tag(VEC[i]), VEC[i][3:0], 8'(i), VEC[i][5], VEC[i][4]);
            if (i + 1 < NV) begin
                multi_mode = VEC[i+1][6];
                drive(1'b1, VEC[i+1][8], VEC[i+1][7], 8'(i + 1));
            end else begin
                drive(1'b0, 1'b0, 1'b0, 8'h00);
            end
        end
        @(negedge clk);
        chk("R8", "wr_en idle", 16'(wr_en), 16'd0);
        chk("R8", "buf_done one cycle", 16'(buf_done), 16'd0);

        // R10 stall: single mode, 3-byte buffers.
        multi_mode = 1'b0; buf_depth = DW'(3);
        drive(1'b1, 1'b1, 1'b0, 8'hA0);
        @(negedge clk);
        check_write("R6", DW'(0), 8'hA0, 1'b0, 1'b0);
        buf_avail = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 8'hA1);
        #0.5;
        chk("R10", "in_ready while open", 16'(in_ready), 16'd1);
        @(negedge clk);
        check_write("R1", DW'(1), 8'hA1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b0, 8'hB0);
        #0.5;
        chk("R10", "in_ready stalled", 16'(in_ready), 16'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10", "no write while stalled", 16'(wr_en), 16'd0);
        end
        buf_avail = 1'b1;
        @(negedge clk);
        check_write("R10", DW'(0), 8'hB0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 8'hB1);
        @(negedge clk);
        check_write("R1", DW'(1), 8'hB1, 1'b1, 1'b1);

        // R4 boundary: 2-byte buffer, one-byte packet closes at offset 0.
        multi_mode = 1'b1; buf_depth = DW'(2);
        drive(1'b1, 1'b1, 1'b1, 8'hC0);
        @(negedge clk);
        check_write("R4", DW'(0), 8'hC0, 1'b1, 1'b0);

        // R11 reset in the middle of a buffer.
        buf_depth = DW'(4);
        drive(1'b1, 1'b1, 1'b0, 8'hD0);
        @(negedge clk);
        check_write("R7", DW'(0), 8'hD0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "wr_en in reset", 16'(wr_en), 16'd0);
        drive(1'b1, 1'b0, 1'b0, 8'hD1);
        @(negedge clk);
        check_write("R11", DW'(0), 8'hD1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule